// File: doc/BRIEF.md
# Drowsy-Mode Direct-Mapped Cache Controller

This block is a direct-mapped data cache that keeps a low-leakage "drowsy" flag for every line. It sits between a processor load/store port (valid/ready request, one-cycle response pulse) and a backing memory port (request pulse, later response pulse). A single free-running window timer fires once every `WINDOW` cycles and marks all lines drowsy at once. No per-line usage history is kept. A drowsy line keeps its tag and data, but it has to be woken before use. Waking takes `WAKE_CYC` stall cycles, plus one extra cycle when the `DROWSY_TAGS` variant is built, because the tag must then also be woken before it can be compared.

Each line holds one word, so a write allocates the whole line without a fetch and is also passed straight through to memory. A read miss issues a memory read and fills the line from the response. Four performance counters report awake hits, drowsy hits, misses and wake-up stall cycles, so the latency rules can be observed from outside.

Below, W = `WAKE_CYC` + (`DROWSY_TAGS` ? 1 : 0), and "accepted in cycle T" means `req_valid` and `req_ready` are both high in cycle T. The line index is `req_addr[IDX_W-1:0]` and the tag is the rest of the address.

Top module: `drowsy_cache_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, all four counters are 0, every line is invalid and awake, and the window timer restarts from zero.
- R2: A read that hits an awake line and is accepted in cycle T gives `rsp_valid`=1 with the stored word in cycle T+1. `req_ready` is 1 in cycle T+1, and the awake-hit counter goes up by one.
- R3: The window timer counts every cycle after reset. On the last cycle of each window (cycle index mod `WINDOW` = `WINDOW`-1) every line becomes drowsy from the next cycle on. An access accepted before that edge finds its line awake.
- R4: A read hit on a drowsy line responds in cycle T+1+W, with `req_ready` low in cycles T+1..T+W. It issues no memory request, because contents are retained. The drowsy-hit counter goes up by one and the stall counter by W.
- R5: A read miss issues one memory read (`mem_req_we`=0, full address). The request appears in cycle T+1 if the line was awake, or in T+1+W if it was drowsy. `req_ready` stays low until the response. `rsp_valid` carries the memory word one cycle after `mem_rsp_valid`, and the miss counter goes up by one.
- R6: A write is performed after any wake-up. It stores tag and data in the line, marks the line valid, and pulses `mem_req_valid` with `mem_req_we`=1, its address and data in the cycle `req_ready` returns high (T+1 awake, T+1+W drowsy). It gives no `rsp_valid`.
- R7: If the window edge coincides with an access accepted or in progress, the line of that access does not go drowsy, and all other lines do.
- R8: An access whose tag differs from the stored tag at the same index is a miss, and the refill replaces the line. The old address then misses.
- R9: A line woken by an access stays awake until the next window edge, so a repeated access to it is an awake hit.
- R10: The counters count accepted accesses (writes included), classified at acceptance as awake hit, drowsy hit or miss. The stall counter counts every wake-up cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | DATA_W | Read data |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_rdata | input | DATA_W | Memory read data |
| perf_awake_hits | output | 32 | Awake-hit count |
| perf_drowsy_hits | output | 32 | Drowsy-hit count |
| perf_misses | output | 32 | Miss count |
| perf_wake_stalls | output | 32 | Wake-up stall cycle count |

## Verification
The window edge that puts every line to sleep can land in the same cycle as the acceptance of a request. The bench keeps its own count of cycles since reset. It uses that count to place a read acceptance exactly on the edge cycle. The outcome is judged from the port-visible latency of what follows: an immediate re-read of the same line must be an awake hit, and a read of another valid line must pay the drowsy wake-up stall. A read one cycle before the edge is also checked, to pin down the edge position.

// File: rtl/drowsy_pkg.sv
package drowsy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAKE   = 2'd1,
        ST_REFILL = 2'd2
    } ctrl_state_e;

    typedef struct packed {
        logic [31:0] awake_hits;
        logic [31:0] drowsy_hits;
        logic [31:0] misses;
        logic [31:0] wake_stalls;
    } perf_t;

    // total wake-up cycles for a drowsy line: line wake plus optional tag wake
    function automatic int wake_total(input int wake_cyc, input bit drowsy_tags);
        return wake_cyc + (drowsy_tags ? 1 : 0);
    endfunction

endpackage

// File: rtl/drowsy_window_timer.sv
module drowsy_window_timer #(
    parameter int WINDOW = 4000
) (
    input  logic clk,
    input  logic rst,
    output logic sleep_pulse
);
    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [CW-1:0] cnt;

    assign sleep_pulse = (cnt == CW'(WINDOW - 1));

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (sleep_pulse) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    // R3: the edge fires on a single cycle and then the window restarts
    p_single_edge_r3: assert property (@(posedge clk) disable iff (rst)
        sleep_pulse |=> !sleep_pulse);

endmodule

// File: rtl/drowsy_state_bits.sv
module drowsy_state_bits #(
    parameter int NUM_LINES = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sleep_all,
    input  logic                          keep_en,
    input  logic [$clog2(NUM_LINES)-1:0]  keep_idx,
    input  logic                          wake_en,
    input  logic [$clog2(NUM_LINES)-1:0]  wake_idx,
    output logic [NUM_LINES-1:0]          drowsy
);
    localparam int IDX_W = $clog2(NUM_LINES);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                drowsy[i] <= 1'b0;
            else if (wake_en && wake_idx == IDX_W'(i))
                drowsy[i] <= 1'b0;
            else if (sleep_all && !(keep_en && keep_idx == IDX_W'(i)))
                drowsy[i] <= 1'b1;
        end
    end

    // R7: the line under access is not put to sleep by the window edge
    p_keep_line_r7: assert property (@(posedge clk) disable iff (rst)
        (sleep_all && keep_en && !drowsy[keep_idx]) |=> !drowsy[$past(keep_idx)]);

    // R3: an edge with no access in flight puts every line to sleep
    p_sleep_all_r3: assert property (@(posedge clk) disable iff (rst)
        (sleep_all && !keep_en) |=> (&drowsy));

    // R9: a finished wake-up leaves the line awake
    p_woken_awake_r9: assert property (@(posedge clk) disable iff (rst)
        wake_en |=> !drowsy[$past(wake_idx)]);

endmodule

// File: rtl/drowsy_line_store.sv
module drowsy_line_store #(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 12,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [$clog2(NUM_LINES)-1:0]  rd_idx,
    output logic                          rd_valid,
    output logic [TAG_W-1:0]              rd_tag,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_LINES)-1:0]  wr_idx,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [DATA_W-1:0]             wr_data
);
    logic [NUM_LINES-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [DATA_W-1:0]    data_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (rst)        valid_q <= '0;
        else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    // R8: a write leaves the written tag and data readable at that index
    p_store_write_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
                   && data_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/drowsy_perf_ctr.sv
module drowsy_perf_ctr (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_awake,
    input  logic              inc_drowsy,
    input  logic              inc_miss,
    input  logic              inc_stall,
    output drowsy_pkg::perf_t perf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            perf <= '0;
        end else begin
            if (inc_awake)  perf.awake_hits  <= perf.awake_hits  + 32'd1;
            if (inc_drowsy) perf.drowsy_hits <= perf.drowsy_hits + 32'd1;
            if (inc_miss)   perf.misses      <= perf.misses      + 32'd1;
            if (inc_stall)  perf.wake_stalls <= perf.wake_stalls + 32'd1;
        end
    end

    // R10: one access is classified into at most one class
    p_one_class_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inc_awake, inc_drowsy, inc_miss}));

endmodule

// File: rtl/drowsy_cache_ctrl.sv
module drowsy_cache_ctrl #(
    parameter int NUM_LINES   = 16,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int WINDOW      = 4000,
    parameter int WAKE_CYC    = 1,
    parameter bit DROWSY_TAGS = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_rdata,
    output logic [31:0]       perf_awake_hits,
    output logic [31:0]       perf_drowsy_hits,
    output logic [31:0]       perf_misses,
    output logic [31:0]       perf_wake_stalls
);
    import drowsy_pkg::*;

    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - IDX_W;
    localparam int WAKE_TOTAL = wake_total(WAKE_CYC, DROWSY_TAGS);
    localparam int WC_W       = $clog2(WAKE_TOTAL + 1);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } access_t;

    ctrl_state_e    state;
    access_t        cur, act;
    logic [WC_W-1:0] wcnt;

    logic              accept, wake_last, do_access, hit, drowsy_now, sleep_pulse;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              st_wr_en;
    logic [DATA_W-1:0] st_wr_data;
    logic [NUM_LINES-1:0] drowsy_q;
    perf_t             perf;

    // ---- lookup path: request in idle, captured access otherwise ----
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign act       = (state == ST_IDLE) ? '{we: req_we, addr: req_addr, wdata: req_wdata} : cur;
    assign lk_idx    = act.addr[IDX_W-1:0];
    assign lk_tag    = act.addr[ADDR_W-1:IDX_W];
    assign hit       = rd_valid && (rd_tag == lk_tag);
    assign drowsy_now = drowsy_q[lk_idx];

    assign wake_last = (state == ST_WAKE) && (wcnt == WC_W'(WAKE_TOTAL - 1));
    assign do_access = (accept && !drowsy_now) || wake_last;

    assign st_wr_en   = (do_access && act.we) || (state == ST_REFILL && mem_rsp_valid);
    assign st_wr_data = (state == ST_REFILL) ? mem_rsp_rdata : act.wdata;

    // ---- sequencing ----
    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            wcnt          <= '0;
            cur           <= '0;
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
        end else begin
            rsp_valid     <= 1'b0;
            mem_req_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cur <= act;
                        if (drowsy_now) begin
                            state <= ST_WAKE;
                            wcnt  <= '0;
                        end
                    end
                end
                ST_WAKE: wcnt <= wcnt + WC_W'(1);
                ST_REFILL: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= mem_rsp_rdata;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (do_access) begin
                if (act.we) begin
                    mem_req_valid <= 1'b1;
                    mem_req_we    <= 1'b1;
                    mem_req_addr  <= act.addr;
                    mem_req_wdata <= act.wdata;
                    state         <= ST_IDLE;
                end else if (hit) begin
                    rsp_valid <= 1'b1;
                    rsp_rdata <= rd_data;
                    state     <= ST_IDLE;
                end else begin
                    mem_req_valid <= 1'b1;
                    mem_req_we    <= 1'b0;
                    mem_req_addr  <= act.addr;
                    state         <= ST_REFILL;
                end
            end
        end
    end

    // ---- sub-blocks ----
    drowsy_window_timer #(.WINDOW(WINDOW)) u_timer (
        .clk(clk), .rst(rst), .sleep_pulse(sleep_pulse)
    );

    drowsy_state_bits #(.NUM_LINES(NUM_LINES)) u_bits (
        .clk(clk), .rst(rst),
        .sleep_all(sleep_pulse),
        .keep_en(accept || state != ST_IDLE),
        .keep_idx(lk_idx),
        .wake_en(wake_last),
        .wake_idx(lk_idx),
        .drowsy(drowsy_q)
    );

    drowsy_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data),
        .wr_en(st_wr_en), .wr_idx(lk_idx), .wr_tag(lk_tag), .wr_data(st_wr_data)
    );

    drowsy_perf_ctr u_perf (
        .clk(clk), .rst(rst),
        .inc_awake(accept && hit && !drowsy_now),
        .inc_drowsy(accept && hit && drowsy_now),
        .inc_miss(accept && !hit),
        .inc_stall(state == ST_WAKE),
        .perf(perf)
    );

    assign perf_awake_hits  = perf.awake_hits;
    assign perf_drowsy_hits = perf.drowsy_hits;
    assign perf_misses      = perf.misses;
    assign perf_wake_stalls = perf.wake_stalls;

    // ---- assertions ----
    // R2: awake read hit answers next cycle with the stored word, port stays open
    p_awake_hit_next_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_we && hit && !drowsy_now) |=>
        (rsp_valid && req_ready && rsp_rdata == $past(rd_data)));

    // R4: accepting on a drowsy line produces neither a response nor a memory request yet
    p_drowsy_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && drowsy_now) |=> (!rsp_valid && !mem_req_valid && !req_ready));

    // R4: a woken hit is served from the retained line, never refetched
    p_no_refetch_r4: assert property (@(posedge clk) disable iff (rst)
        (wake_last && hit && !cur.we) |=> (rsp_valid && !mem_req_valid));

    // R5: refill data is forwarded one cycle after memory returns it
    p_refill_fwd_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REFILL && mem_rsp_valid) |=>
        (rsp_valid && rsp_rdata == $past(mem_rsp_rdata)));

    // R6: an awake write is passed through to memory the next cycle
    p_write_through_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && req_we && !drowsy_now) |=>
        (mem_req_valid && mem_req_we && mem_req_addr == $past(req_addr)
         && mem_req_wdata == $past(req_wdata)));

    // R4: the wake counter never runs past its configured length
    p_wake_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAKE) |-> (wcnt < WC_W'(WAKE_TOTAL)));

endmodule

// File: tb/tb_drowsy_cache_ctrl.sv
`timescale 1ns/1ps
module tb_drowsy_cache_ctrl;

    localparam int NL  = 8;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int WIN = 64;
    localparam int WK  = 2;
    localparam bit DT  = 1'b1;
    localparam int EW  = WK + (DT ? 1 : 0);
    localparam int ML  = 2;

    localparam int K_AH = 0, K_DH = 1, K_AM = 2, K_DM = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_req_valid, mem_req_we;
    logic [DW-1:0] rsp_rdata, mem_req_wdata;
    logic [AW-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;
    logic [31:0] perf_awake_hits, perf_drowsy_hits, perf_misses, perf_wake_stalls;

    always #2.5 clk = ~clk;

    drowsy_cache_ctrl #(
        .NUM_LINES(NL), .ADDR_W(AW), .DATA_W(DW), .WINDOW(WIN),
        .WAKE_CYC(WK), .DROWSY_TAGS(DT)
    ) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .perf_awake_hits(perf_awake_hits), .perf_drowsy_hits(perf_drowsy_hits),
        .perf_misses(perf_misses), .perf_wake_stalls(perf_wake_stalls)
    );

    int total = 0, bad = 0, cyc = 0, rd_count = 0;
    int e_ah = 0, e_dh = 0, e_miss = 0, e_stall = 0;
    logic [DW-1:0] bmem [4096];
    logic [DW-1:0] refm [4096];

    function automatic logic [DW-1:0] init_word(input int a);
        return {20'hC0FEE, 12'(a)} ^ (32'(a) << 20);
    endfunction

    function automatic int exp_lat(input int kind);
        case (kind)
            K_AH:    return 1;
            K_DH:    return 1 + EW;
            K_AM:    return 2 + ML;
            default: return EW + 2 + ML;
        endcase
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic tally(input int kind);
        case (kind)
            K_AH: e_ah++;
            K_DH: begin e_dh++; e_stall += EW; end
            K_AM: e_miss++;
            default: begin e_miss++; e_stall += EW; end
        endcase
    endtask

    // cycles since reset release, equals the design's window phase count
    initial forever begin
        @(posedge clk);
        cyc <= rst ? 0 : cyc + 1;
    end

    // backing memory model: fixed latency reads, write-through sink
    initial begin
        int cd;
        logic [AW-1:0] pa;
        cd = 0; pa = '0;
        for (int i = 0; i < 4096; i++) begin
            bmem[i] = init_word(i);
            refm[i] = init_word(i);
        end
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_rdata = bmem[pa];
                end
            end
            if (mem_req_valid) begin
                if (mem_req_we) bmem[mem_req_addr] = mem_req_wdata;
                else begin pa = mem_req_addr; cd = ML; rd_count++; end
            end
        end
    end

    task automatic wait_phase(input int p);
        while ((cyc % WIN) != p) @(negedge clk);
    endtask

    // called and returns at a negedge
    task automatic do_read(input logic [AW-1:0] a, input int kind, input string rq);
        int lat, rd0;
        rd0 = rd_count;
        req_valid = 1'b1; req_we = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (kind != K_AH) chk(rq, "ready low while stalled", 32'(req_ready), 32'd0);
        while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
        chk(rq, $sformatf("read latency @%0h", a), 32'(lat), 32'(exp_lat(kind)));
        chk(rq, $sformatf("read data @%0h", a), rsp_rdata, refm[a]);
        chk(rq, "memory reads issued", 32'(rd_count - rd0), (kind >= K_AM) ? 32'd1 : 32'd0);
        if (kind == K_AH) chk(rq, "ready with response", 32'(req_ready), 32'd1);
        tally(kind);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int kind, input string rq);
        int lat;
        req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
        lat = 1;
        while (!req_ready && lat < 60) begin @(negedge clk); lat++; end
        chk(rq, "write latency", 32'(lat), (kind == K_AH || kind == K_AM) ? 32'd1 : 32'(1 + EW));
        chk(rq, "write-through pulse", {mem_req_valid, mem_req_we}, 32'b11);
        chk(rq, "write-through addr", 32'(mem_req_addr), 32'(a));
        chk(rq, "write-through data", mem_req_wdata, d);
        chk(rq, "no read response on write", 32'(rsp_valid), 32'd0);
        refm[a] = d;
        tally(kind);
    endtask

    task automatic t_reset;
        chk("R1", "ready", 32'(req_ready), 32'd1);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);
        chk("R1", "counters", perf_awake_hits | perf_drowsy_hits | perf_misses | perf_wake_stalls, 32'd0);
    endtask

    task automatic t_fill_hit;
        do_read(12'h013, K_AM, "R1 R5 first read misses on awake line");
        do_read(12'h013, K_AH, "R2 awake hit");
    endtask

    task automatic t_write_through;
        do_write(12'h025, 32'hDEAD_0025, K_AM, "R6 awake write miss");
        do_read(12'h025, K_AH, "R6 read back written word");
    endtask

    task automatic t_window_edge;
        wait_phase(WIN - 2);
        do_read(12'h025, K_AH, "R3 access before window edge is awake");
        wait_phase(0);
        do_read(12'h013, K_DH, "R3 R4 drowsy hit after edge");
        do_read(12'h013, K_AH, "R9 woken line stays awake");
    endtask

    task automatic t_conflict;
        do_read(12'h033, K_AM, "R8 conflict miss replaces line");
        do_read(12'h013, K_AM, "R8 old tag now misses");
        do_read(12'h016, K_DM, "R5 drowsy miss refill");
    endtask

    task automatic t_pulse_overlap;
        wait_phase(0);
        do_read(12'h013, K_DH, "R7 setup wake line 3");
        do_read(12'h025, K_DH, "R7 setup wake line 5");
        wait_phase(WIN - 1);
        do_read(12'h013, K_AH, "R7 access on edge cycle");
        do_read(12'h013, K_AH, "R7 accessed line kept awake");
        do_read(12'h025, K_DH, "R7 other line went drowsy");
    endtask

    task automatic t_drowsy_write;
        do_write(12'h017, 32'hBEEF_0017, K_DM, "R6 R4 write to drowsy line");
        do_read(12'h017, K_AH, "R6 read back after drowsy write");
        do_read(12'h016, K_DH, "R4 refilled line retained while drowsy");
    endtask

    task automatic t_counters;
        chk("R10", "awake hits", perf_awake_hits, 32'(e_ah));
        chk("R10", "drowsy hits", perf_drowsy_hits, 32'(e_dh));
        chk("R10", "misses", perf_misses, 32'(e_miss));
        chk("R10", "wake stalls", perf_wake_stalls, 32'(e_stall));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill_hit();
        t_write_through();
        t_window_edge();
        t_conflict();
        t_pulse_overlap();
        t_drowsy_write();
        t_counters();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule